// File: doc/BRIEF.md
# Fast-Sweep Partial Readout Sequencer

This block orders the vertical transfer work of an image sensor frame when only a band of lines is wanted. A frame strobe starts a fixed-length fast sweep that clears the whole array. Readout strobes then move the charge into the vertical registers. A second fast sweep of programmable length discards the lines above the wanted band. Ordinary line-by-line transfer follows until the next frame strobe. With the partial mode off, the block stays in ordinary transfer and gives one readout per frame.

The block works at line resolution. For each line period it reports how many fast vertical shifts the waveform generator downstream has to produce, and it reports the current phase. It also gives two one-cycle readout strobes and a flag that marks ordinary transfer. The partial-mode enable, the full/draft resolution flag and the sweep length are sampled together on the frame strobe, so each frame runs with one consistent set of values.

Top module: `fsweep_seq`

## Requirements
- R1: After reset, `phase_o` is 2 (ordinary transfer), `shifts_o` is 1, `xfer_normal_o` is 1, and both readout strobes are low.
- R2: A frame strobe with `fs_en_i`=1 puts the block, one cycle later, in the clearing sweep: `phase_o`=0, `shifts_o`=20, `xfer_normal_o`=0.
- R3: The clearing sweep lasts exactly 69 line strobes. After the 68th it is still in phase 0, and the 69th ends it.
- R4: When the clearing sweep ends, `rd_a_o` pulses high for exactly one cycle. `rd_b_o` pulses with it only if the captured resolution flag is 1 (full).
- R5: The skip sweep (`phase_o`=1) lasts exactly the captured `sweep_len_i` line strobes. During it `shifts_o` is 8 when the captured flag is 1 and 20 when it is 0. Lengths from 1 to 127 are accepted.
- R6: A captured sweep length of 0 sends the block from the clearing sweep straight to ordinary transfer (`phase_o`=2), with the readout pulse still issued.
- R7: In ordinary transfer `shifts_o` is 1 and `xfer_normal_o` is 1. Line strobes neither change the phase nor produce readout strobes.
- R8: A frame strobe with `fs_en_i`=0 leaves the block in ordinary transfer and, one cycle later, pulses `rd_a_o`. `rd_b_o` pulses only if `fine_i` is 1.
- R9: A frame strobe restarts the sequence from any phase, including mid-sweep. It takes priority over a line strobe in the same cycle, and the line count restarts from zero.
- R10: `fs_en_i`, `fine_i` and `sweep_len_i` are sampled only on a frame strobe. Changes between frame strobes have no effect on the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr_i | input | 1 | Frame strobe, one cycle per frame |
| hr_i | input | 1 | Line strobe, one cycle per line |
| fs_en_i | input | 1 | Partial-frame sequencing enable |
| fine_i | input | 1 | 1 = full resolution, 0 = draft |
| sweep_len_i | input | 7 | Skip-sweep length in lines |
| shifts_o | output | 5 | Fast vertical shifts for the current line |
| rd_a_o | output | 1 | Readout strobe A |
| rd_b_o | output | 1 | Readout strobe B |
| xfer_normal_o | output | 1 | High during ordinary transfer |
| phase_o | output | 2 | 0 = clearing sweep, 1 = skip sweep, 2 = ordinary transfer |

## Verification
The hardest case to reach is a frame strobe that lands in the same cycle as a line strobe while the skip sweep is partly done. The stimulus first plays a full clearing sweep and part of a skip sweep. It then raises both strobes together. After that it counts out a complete new 69-line sweep, which shows that the line count was reset and not simply continued. During the same frame it changes every setting input, so any sampling of those inputs outside the frame strobe shows up in the readout strobes and in the shift counts.

// File: rtl/fsweep_pkg.sv
package fsweep_pkg;
  typedef enum logic [1:0] {
    PH_Z = 2'd0,
    PH_X = 2'd1,
    PH_Y = 2'd2
  } phase_e;
endpackage

// File: rtl/fsweep_cfg.sv
module fsweep_cfg #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fr_i,
  input  logic             fs_en_i,
  input  logic             fine_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             fs_q_o,
  output logic             fine_q_o,
  output logic [LEN_W-1:0] len_q_o
);
  logic             fs_d, fine_d;
  logic [LEN_W-1:0] len_d;

  always_comb begin
    fs_d   = fs_q_o;
    fine_d = fine_q_o;
    len_d  = len_q_o;
    if (fr_i) begin
      fs_d   = fs_en_i;
      fine_d = fine_i;
      len_d  = len_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q_o   <= 1'b0;
      fine_q_o <= 1'b0;
      len_q_o  <= '0;
    end else begin
      fs_q_o   <= fs_d;
      fine_q_o <= fine_d;
      len_q_o  <= len_d;
    end
  end

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fr_i |=> ($stable(fine_q_o) && $stable(len_q_o)));
endmodule

// File: rtl/fsweep_ctrl.sv
module fsweep_ctrl
  import fsweep_pkg::*;
#(
  parameter int LEN_W   = 7,
  parameter int Z_LINES = 69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fr_i,
  input  logic             hr_i,
  input  logic             fs_now_i,
  input  logic             fine_now_i,
  input  logic             fine_q_i,
  input  logic [LEN_W-1:0] len_q_i,
  output phase_e           phase_o,
  output logic             rd_a_o,
  output logic             rd_b_o
);
  localparam int ZW    = $clog2(Z_LINES + 1);
  localparam int CNT_W = (ZW > LEN_W) ? ZW : LEN_W;
  localparam logic [CNT_W-1:0] Z_LAST = CNT_W'(Z_LINES - 1);

  phase_e           phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rda_d, rdb_d;
  logic [CNT_W-1:0] len_ext;

  assign len_ext = CNT_W'(len_q_i);

  always_comb begin
    phase_d = phase_o;
    cnt_d   = cnt_q;
    rda_d   = 1'b0;
    rdb_d   = 1'b0;
    if (fr_i) begin
      cnt_d = '0;
      if (fs_now_i) begin
        phase_d = PH_Z;
      end else begin
        phase_d = PH_Y;
        rda_d   = 1'b1;
        rdb_d   = fine_now_i;
      end
    end else if (hr_i) begin
      case (phase_o)
        PH_Z: begin
          if (cnt_q == Z_LAST) begin
            cnt_d   = '0;
            rda_d   = 1'b1;
            rdb_d   = fine_q_i;
            phase_d = (len_q_i == '0) ? PH_Y : PH_X;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_X: begin
          if ((cnt_q + 1'b1) == len_ext) begin
            cnt_d   = '0;
            phase_d = PH_Y;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o <= PH_Y;
      cnt_q   <= '0;
      rd_a_o  <= 1'b0;
      rd_b_o  <= 1'b0;
    end else begin
      phase_o <= phase_d;
      cnt_q   <= cnt_d;
      rd_a_o  <= rda_d;
      rd_b_o  <= rdb_d;
    end
  end

  // R3
  z_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_Z) |-> (cnt_q <= Z_LAST));
  // R5
  x_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_X) |-> (cnt_q < len_ext));
  // R4
  rdb_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_o |-> rd_a_o);
  // R9
  fr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr_i |=> (cnt_q == '0));
  // R7
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_Y && !fr_i) |=> (phase_o == PH_Y && !rd_a_o));
endmodule

// File: rtl/fsweep_shift_dec.sv
module fsweep_shift_dec
  import fsweep_pkg::*;
#(
  parameter int SH_W        = 5,
  parameter int Z_SHIFT     = 20,
  parameter int FINE_SHIFT  = 8,
  parameter int DRAFT_SHIFT = 20,
  parameter int NORM_SHIFT  = 1
) (
  input  phase_e          phase_i,
  input  logic            fine_q_i,
  output logic [SH_W-1:0] shifts_o,
  output logic            xfer_normal_o
);
  always_comb begin
    xfer_normal_o = 1'b0;
    case (phase_i)
      PH_Z:    shifts_o = SH_W'(Z_SHIFT);
      PH_X:    shifts_o = fine_q_i ? SH_W'(FINE_SHIFT) : SH_W'(DRAFT_SHIFT);
      default: begin
        shifts_o      = SH_W'(NORM_SHIFT);
        xfer_normal_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fsweep_seq.sv
module fsweep_seq
  import fsweep_pkg::*;
#(
  parameter int LEN_W       = 7,
  parameter int SH_W        = 5,
  parameter int Z_LINES     = 69,
  parameter int Z_SHIFT     = 20,
  parameter int FINE_SHIFT  = 8,
  parameter int DRAFT_SHIFT = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fr_i,
  input  logic             hr_i,
  input  logic             fs_en_i,
  input  logic             fine_i,
  input  logic [LEN_W-1:0] sweep_len_i,
  output logic [SH_W-1:0]  shifts_o,
  output logic             rd_a_o,
  output logic             rd_b_o,
  output logic             xfer_normal_o,
  output logic [1:0]       phase_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             fs_q, fine_q;
  logic [LEN_W-1:0] len_q;
  phase_e           phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fsweep_cfg #(.LEN_W(LEN_W)) cfg_i (
    .clk(clk), .rst_n(rst_int_n), .fr_i(fr_i), .fs_en_i(fs_en_i),
    .fine_i(fine_i), .len_i(sweep_len_i),
    .fs_q_o(fs_q), .fine_q_o(fine_q), .len_q_o(len_q)
  );

  fsweep_ctrl #(.LEN_W(LEN_W), .Z_LINES(Z_LINES)) ctrl_i (
    .clk(clk), .rst_n(rst_int_n), .fr_i(fr_i), .hr_i(hr_i),
    .fs_now_i(fs_en_i), .fine_now_i(fine_i), .fine_q_i(fine_q),
    .len_q_i(len_q), .phase_o(phase), .rd_a_o(rd_a_o), .rd_b_o(rd_b_o)
  );

  fsweep_shift_dec #(.SH_W(SH_W), .Z_SHIFT(Z_SHIFT), .FINE_SHIFT(FINE_SHIFT),
                     .DRAFT_SHIFT(DRAFT_SHIFT), .NORM_SHIFT(1)) dec_i (
    .phase_i(phase), .fine_q_i(fine_q),
    .shifts_o(shifts_o), .xfer_normal_o(xfer_normal_o)
  );

  assign phase_o = phase;

  // R2
  fr_to_z_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fr_i && fs_en_i) |=> (phase_o == 2'd0 && shifts_o == SH_W'(Z_SHIFT)));
  // R8
  fr_plain_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fr_i && !fs_en_i) |=> (rd_a_o && xfer_normal_o && !fs_q));
endmodule

// File: tb/fsweep_seq_tb_top.sv
module fsweep_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, fr, hr, fs_en, fine;
  logic [6:0] len;
  logic [4:0] shifts;
  logic       rd_a, rd_b, xn;
  logic [1:0] phase;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fsweep_seq dut_i (
    .clk(clk), .rst_n(rst_n), .fr_i(fr), .hr_i(hr), .fs_en_i(fs_en),
    .fine_i(fine), .sweep_len_i(len), .shifts_o(shifts), .rd_a_o(rd_a),
    .rd_b_o(rd_b), .xfer_normal_o(xn), .phase_o(phase)
  );

  // fs_en, fine, len
  localparam logic [8:0] VECS [0:6] = '{
    {1'b1, 1'b1, 7'd3},
    {1'b1, 1'b0, 7'd5},
    {1'b1, 1'b1, 7'd0},
    {1'b1, 1'b0, 7'd1},
    {1'b0, 1'b1, 7'd0},
    {1'b0, 1'b0, 7'd9},
    {1'b1, 1'b0, 7'd127}
  };

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_fr();
    @(negedge clk); fr = 1'b1;
    @(negedge clk); fr = 1'b0;
  endtask

  task automatic pulse_hr();
    @(negedge clk); hr = 1'b1;
    @(negedge clk); hr = 1'b0;
  endtask

  task automatic run_frame(logic f, logic fn, logic [6:0] l);
    fs_en = f; fine = fn; len = l;
    pulse_fr();
    if (f) begin
      chk("R2 phase", phase, 0);
      chk("R2 shifts", shifts, 20);
      chk("R2 xfer", xn, 0);
      repeat (68) pulse_hr();
      chk("R3 still sweeping", phase, 0);
      pulse_hr();
      chk("R3/R6 phase after sweep", phase, (l == 0) ? 2 : 1);
      chk("R4 rd_a", rd_a, 1);
      chk("R4 rd_b", rd_b, fn);
      if (l != 0) begin
        chk("R5 shifts", shifts, fn ? 8 : 20);
        repeat (int'(l) - 1) pulse_hr();
        chk("R5 still skipping", phase, 1);
        pulse_hr();
        chk("R5 skip done", phase, 2);
      end
      chk("R7 shifts", shifts, 1);
      chk("R7 xfer", xn, 1);
      pulse_hr();
      chk("R7 phase held", phase, 2);
      chk("R7 no readout", rd_a, 0);
    end else begin
      chk("R8 phase", phase, 2);
      chk("R8 rd_a", rd_a, 1);
      chk("R8 rd_b", rd_b, fn);
      @(negedge clk);
      chk("R8 pulse width", rd_a, 0);
      pulse_hr();
      chk("R7 hr in transfer", phase, 2);
    end
  endtask

  initial begin
    rst_n = 1'b0; fr = 1'b0; hr = 1'b0; fs_en = 1'b0; fine = 1'b0; len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 phase", phase, 2);
    chk("R1 shifts", shifts, 1);
    chk("R1 xfer", xn, 1);
    chk("R1 rd_a", rd_a, 0);
    chk("R1 rd_b", rd_b, 0);

    for (int i = 0; i < 7; i++) run_frame(VECS[i][8], VECS[i][7], VECS[i][6:0]);

    // R9: frame strobe together with a line strobe during the skip sweep
    fs_en = 1'b1; fine = 1'b1; len = 7'd10;
    pulse_fr();
    repeat (71) pulse_hr();
    chk("R9 mid skip", phase, 1);
    @(negedge clk); fr = 1'b1; hr = 1'b1;
    @(negedge clk); fr = 1'b0; hr = 1'b0;
    chk("R9 restart phase", phase, 0);
    // R10: change every setting input mid-frame
    fs_en = 1'b0; fine = 1'b0; len = 7'd2;
    repeat (68) pulse_hr();
    chk("R9 count restarted", phase, 0);
    pulse_hr();
    chk("R10 phase", phase, 1);
    chk("R10 rd_b uses captured flag", rd_b, 1);
    chk("R10 shifts", shifts, 8);
    repeat (9) pulse_hr();
    chk("R10 captured length", phase, 1);
    pulse_hr();
    chk("R10 length end", phase, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule